// File: doc/BRIEF.md
# Qualified Event Counter

This block is one programmable performance-monitoring counter. In every clock cycle an upstream event source presents a small count of event occurrences (0 to 4) and the current processor privilege level (0 to 3). A set of qualifiers decides how much the 48-bit accumulator grows in that cycle:

- a privilege filter;
- an optional per-cycle threshold compare, which can be inverted;
- an optional conversion of the threshold result into rising-edge counting.

Software sets the qualifiers in a configuration register and can read back both that register and the running count. Software can also overwrite the count. When the count wraps past all-ones and interrupts are enabled, a sticky flag drives an interrupt request until software clears it.

The configuration register and the count take new values at the clock edge that follows a write. The increment in any cycle is computed from the configuration held in that cycle.

Top module: `evt_ctr_qual`

## Requirements
- R1: After reset the count reads 0, the configuration reads 0 and irq is low.
- R2: Configuration bit 0 is the global enable. While it is 0 the count never changes, except through a software write.
- R3: When the threshold field (configuration bits 8:6) is zero, an enabled counter adds the raw event count of each privilege-qualified cycle. The invert bit (bit 4) and the edge bit (bit 3) have no effect in this case.
- R4: With a non-zero threshold and invert clear, the counter adds one in each qualified cycle whose event count is greater than or equal to the threshold.
- R5: With a non-zero threshold and invert set, the counter adds one in each qualified cycle whose event count is below the threshold.
- R6: With a non-zero threshold and edge set, the counter adds one only when the qualified condition goes from false to true. The remembered previous condition is forced to false whenever the enable is 0 or the threshold is zero.
- R7: Bit 1 enables counting at privilege level 0, and bit 2 enables counting at levels 1 to 3. When both bits are 0, every level counts.
- R8: A count write (cnt_we) loads cnt_wdata at the next edge. It takes priority over any increment in the same cycle.
- R9: An increment that carries out of the 48-bit count wraps it. If bit 5 (interrupt enable) is set, the wrap sets a sticky flag that drives irq high. The flag clears only on ovf_clr, and a new wrap in the same cycle wins over the clear.
- R10: A configuration write (cfg_we) loads cfg_wdata at the next edge, and cfg_rdata returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_cnt | input | 3 | Event occurrences this cycle (0 to 4) |
| priv_lvl | input | 2 | Current privilege level |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 9 | Configuration write value |
| cfg_rdata | output | 9 | Stored configuration |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | 48 | Count write value |
| cnt_rdata | output | 48 | Current count |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions check the following in every cycle:

- the count stays still while the counter is disabled;
- the count never grows by more than four, or by more than one when a threshold is set;
- software loads of the count and of the configuration land;
- irq stays set until it is cleared, and rises only with the interrupt enable set.

The actual amounts added need the bench's scenarios to show. These cover the threshold and inverted compares, one count per rising edge, the clearing of the edge history on disable, the privilege filter combinations, and the wrap at the top of the count. They are compared against a behavioural model on every clock.

// File: rtl/ecq_pkg.sv
package ecq_pkg;
  localparam int THR_W = 3;

  // Field order is fixed: software encodes it (see R2..R10).
  typedef struct packed {
    logic [THR_W-1:0] thr;     // 8:6
    logic             ien;     // 5
    logic             inv;     // 4
    logic             edge_en; // 3
    logic             usr;     // 2
    logic             os;      // 1
    logic             en;      // 0
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/ecq_qualify.sv
module ecq_qualify
  import ecq_pkg::*;
#(
  parameter int EVT_W  = 3,
  parameter int PRIV_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_t              cfg,
  input  logic [EVT_W-1:0]  evt,
  input  logic [PRIV_W-1:0] priv,
  output logic [EVT_W-1:0]  inc
);
  localparam int CMP_W = (EVT_W > THR_W) ? EVT_W : THR_W;

  logic             prev_q, prev_d;
  logic             priv_ok, thr_on, cmp_ge, cond, qual;
  logic [CMP_W-1:0] evt_x, thr_x;

  always_comb begin
    evt_x   = CMP_W'(evt);
    thr_x   = CMP_W'(cfg.thr);
    thr_on  = (cfg.thr != '0);
    if (!cfg.os && !cfg.usr) priv_ok = 1'b1;
    else if (priv == '0)     priv_ok = cfg.os;
    else                     priv_ok = cfg.usr;
    cmp_ge  = (evt_x >= thr_x);
    cond    = cfg.inv ? !cmp_ge : cmp_ge;
    qual    = cond && priv_ok;
    prev_d  = (cfg.en && thr_on) ? qual : 1'b0;
    if (!cfg.en)           inc = '0;
    else if (!thr_on)      inc = priv_ok ? evt : '0;
    else if (cfg.edge_en)  inc = EVT_W'(qual && !prev_q);
    else                   inc = EVT_W'(qual);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/ecq_accum.sv
module ecq_accum #(
  parameter int CNT_W = 48,
  parameter int EVT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] inc,
  input  logic             ien,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_q
);
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt_d;
  logic             ovf_d, cnt_ce, wrap;

  always_comb begin
    sum    = {1'b0, cnt_q} + (CNT_W+1)'(inc);
    wrap   = !ld && sum[CNT_W];
    cnt_ce = ld || (inc != '0);
    cnt_d  = ld ? ld_val : sum[CNT_W-1:0];
    if (wrap && ien) ovf_d = 1'b1;
    else if (ovf_clr) ovf_d = 1'b0;
    else              ovf_d = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (cnt_ce) cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end
endmodule

// File: rtl/evt_ctr_qual.sv
module evt_ctr_qual
  import ecq_pkg::*;
#(
  parameter int CNT_W  = 48,
  parameter int EVT_W  = 3,
  parameter int PRIV_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  evt_cnt,
  input  logic [PRIV_W-1:0] priv_lvl,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_wdata,
  output logic [CNT_W-1:0]  cnt_rdata,
  input  logic              ovf_clr,
  output logic              irq
);
  cfg_t             cfg_q;
  logic [EVT_W-1:0] inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_t'(cfg_wdata);
  end

  ecq_qualify #(.EVT_W(EVT_W), .PRIV_W(PRIV_W)) qual_i (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q),
    .evt(evt_cnt), .priv(priv_lvl), .inc(inc)
  );

  ecq_accum #(.CNT_W(CNT_W), .EVT_W(EVT_W)) acc_i (
    .clk(clk), .rst_n(rst_n), .inc(inc), .ien(cfg_q.ien),
    .ld(cnt_we), .ld_val(cnt_wdata), .ovf_clr(ovf_clr),
    .cnt_q(cnt_rdata), .ovf_q(irq)
  );

  assign cfg_rdata = cfg_q;
endmodule

// File: rtl/ecq_chk.sv
module ecq_chk #(
  parameter int CNT_W = 48,
  parameter int CFG_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic             cnt_we,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic [CNT_W-1:0] cnt_rdata,
  input logic             ovf_clr,
  input logic             irq
);
  // R2
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rdata[0] && !cnt_we) |=> (cnt_rdata == $past(cnt_rdata)));
  // R3
  raw_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_we |=> ((cnt_rdata - $past(cnt_rdata)) <= CNT_W'(4)));
  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[8:6] != 3'd0 && !cnt_we) |=> ((cnt_rdata - $past(cnt_rdata)) <= CNT_W'(1)));
  // R8
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt_rdata == $past(cnt_wdata)));
  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ovf_clr) |=> irq);
  // R9
  irq_ien_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cfg_rdata[5]));
  // R10
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_rdata == $past(cfg_wdata)));
endmodule

bind evt_ctr_qual ecq_chk #(.CNT_W(CNT_W), .CFG_W(ecq_pkg::CFG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
  .cnt_rdata(cnt_rdata), .ovf_clr(ovf_clr), .irq(irq)
);

// File: tb/evt_ctr_qual_tb_top.sv
module evt_ctr_qual_tb_top;
  localparam int CW = 48;
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    evt_cnt = '0;
  logic [1:0]    priv_lvl = '0;
  logic          cfg_we = 1'b0;
  logic [8:0]    cfg_wdata = '0;
  logic [8:0]    cfg_rdata;
  logic          cnt_we = 1'b0;
  logic [CW-1:0] cnt_wdata = '0;
  logic [CW-1:0] cnt_rdata;
  logic          ovf_clr = 1'b0;
  logic          irq;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // behavioural model state
  logic [CW-1:0] m_cnt;
  logic [8:0]    m_cfg;
  bit            m_ovf, m_prev;

  always #4 clk = ~clk;

  evt_ctr_qual dut_i (
    .clk(clk), .rst_n(rst_n), .evt_cnt(evt_cnt), .priv_lvl(priv_lvl),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata),
    .ovf_clr(ovf_clr), .irq(irq)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = '0; m_cfg = '0; m_ovf = 0; m_prev = 0;
    end else begin
      bit en, os, usr, edg, inv, ien, pok, q, set;
      int thr, ev, add;
      logic [CW:0] s;
      en = m_cfg[0]; os = m_cfg[1]; usr = m_cfg[2]; edg = m_cfg[3];
      inv = m_cfg[4]; ien = m_cfg[5]; thr = int'(m_cfg[8:6]); ev = int'(evt_cnt);
      pok = (!os && !usr) ? 1'b1 : ((priv_lvl == 0) ? os : usr);
      q = (inv ? (ev < thr) : (ev >= thr)) && pok;
      if (!en) add = 0;
      else if (thr == 0) add = pok ? ev : 0;
      else if (edg) add = (q && !m_prev) ? 1 : 0;
      else add = q ? 1 : 0;
      set = 0;
      if (cnt_we) m_cnt = cnt_wdata;
      else begin
        s = {1'b0, m_cnt} + (CW+1)'(add);
        set = s[CW] && ien;
        m_cnt = s[CW-1:0];
      end
      if (set) m_ovf = 1;
      else if (ovf_clr) m_ovf = 0;
      m_prev = (en && thr != 0) ? q : 1'b0;
      if (cfg_we) m_cfg = cfg_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (cnt_rdata !== m_cnt || irq !== m_ovf || cfg_rdata !== m_cfg) begin
        n_bad++;
        $display("FAIL %s: cnt=%0h irq=%0b cfg=%0h expected cnt=%0h irq=%0b cfg=%0h",
                 cur_req, cnt_rdata, irq, cfg_rdata, m_cnt, m_ovf, m_cfg);
      end
    end
  end

  task automatic check(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int e, int p);
    evt_cnt = 3'(e); priv_lvl = 2'(p);
    @(negedge clk);
    cfg_we = 0; cnt_we = 0; ovf_clr = 0; evt_cnt = '0;
  endtask

  task automatic set_cfg(logic [8:0] v);
    cfg_we = 1; cfg_wdata = v; step(0, 0);
  endtask

  task automatic set_cnt(logic [CW-1:0] v);
    cnt_we = 1; cnt_wdata = v; step(0, 0);
  endtask

  initial begin
    #(8 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", cnt_rdata, '0); check("R1", CW'(irq), '0); check("R1", CW'(cfg_rdata), '0);

    // R2 disabled: nothing counts
    cur_req = "R2";
    repeat (4) step(4, 0);
    check("R2", cnt_rdata, '0);

    // R10 config readback; R3 raw sum with zero threshold
    cur_req = "R10";
    set_cfg(9'h001);
    check("R10", CW'(cfg_rdata), 48'h1);
    cur_req = "R3";
    step(1, 0); step(2, 1); step(3, 2); step(4, 3); step(0, 0);
    check("R3", cnt_rdata, 48'd10);
    set_cfg(9'h019);              // en | edge | inv, threshold 0
    set_cnt('0);
    step(3, 0); step(3, 0);
    check("R3", cnt_rdata, 48'd6);

    // R4 threshold 2
    cur_req = "R4";
    set_cfg(9'h081); set_cnt('0);
    step(0, 0); step(1, 0); step(2, 0); step(3, 0); step(4, 0); step(2, 0);
    check("R4", cnt_rdata, 48'd4);

    // R5 inverted threshold 2
    cur_req = "R5";
    set_cfg(9'h091); set_cnt('0);
    step(0, 0); step(1, 0); step(2, 0); step(3, 0); step(4, 0); step(2, 0);
    check("R5", cnt_rdata, 48'd2);

    // R6 edge counting, threshold 2
    cur_req = "R6";
    set_cfg(9'h089); set_cnt('0);
    step(3, 0); step(3, 0); step(0, 0); step(4, 0); step(4, 0); step(4, 0);
    step(1, 0); step(2, 0);
    check("R6", cnt_rdata, 48'd3);
    step(3, 0);                   // condition still true: no count
    check("R6", cnt_rdata, 48'd3);
    cfg_we = 1; cfg_wdata = 9'h088; step(3, 0);   // disable
    step(3, 0);                   // disabled cycle clears history
    cfg_we = 1; cfg_wdata = 9'h089; step(3, 0);
    step(3, 0);                   // re-enabled, true again: one count
    check("R6", cnt_rdata, 48'd4);

    // R7 privilege filtering, zero threshold
    cur_req = "R7";
    set_cfg(9'h003); set_cnt('0);  // level 0 only
    step(1, 0); step(1, 2); step(1, 3);
    check("R7", cnt_rdata, 48'd1);
    set_cfg(9'h005); set_cnt('0);  // levels 1-3 only
    step(1, 0); step(1, 1); step(1, 3);
    check("R7", cnt_rdata, 48'd2);
    set_cfg(9'h001); set_cnt('0);  // neither: all levels
    step(1, 0); step(1, 1); step(1, 2); step(1, 3);
    check("R7", cnt_rdata, 48'd4);

    // R8 write beats increment
    cur_req = "R8";
    cnt_we = 1; cnt_wdata = 48'h123456; step(4, 0);
    check("R8", cnt_rdata, 48'h123456);

    // R9 wrap with interrupt enable
    cur_req = "R9";
    set_cfg(9'h021); set_cnt(MAXV - 1);
    step(3, 0);
    check("R9", cnt_rdata, 48'd1);
    check("R9", CW'(irq), 48'd1);
    step(1, 0); step(0, 0);
    check("R9", CW'(irq), 48'd1);
    ovf_clr = 1; step(0, 0);
    check("R9", CW'(irq), 48'd0);
    set_cfg(9'h001); set_cnt(MAXV);
    step(1, 0);
    check("R9", cnt_rdata, 48'd0);
    check("R9", CW'(irq), 48'd0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule